// File: doc/BRIEF.md
# Receive/Transmit Interrupt Moderator

This block sits between the completion strobes of a network controller's DMA engine and its interrupt status logic. It holds back receive and transmit completion interrupts, so that one interrupt covers several finished packets, and it raises a direction's interrupt once enough completions have gathered or a holding timer runs out, whichever happens first. Each direction has its own packet threshold and its own timer. The transmit timer runs in steps sixteen times coarser than the receive timer.

Software sets the behaviour through one 32-bit control word that it can write and read back. An all-zero word passes every completion straight through. The continuous-mode bit selects between two behaviours. With the bit set, mitigation re-arms after every moderated interrupt. With the bit clear, there is a single moderated interrupt, then pass-through until the next write. A cycle-size bit selects the time unit: either every base tick or every eighth base tick.

Top module: `irq_moderator`

## Requirements
- R1: After reset both interrupt outputs are low, the control readback is 0, and every completion is passed straight through.
- R2: When a direction's packet-count field and timer field are both 0, including the all-zero control word, each completion pulse on that direction raises that direction's interrupt for one cycle, in the cycle after the pulse.
- R3: A nonzero packet-count field N raises the interrupt one cycle after the Nth completion counted since that direction's last interrupt or last control write. The count then restarts from zero. Receive count is bits 19:17 and transmit count is bits 26:24.
- R4: When a direction's count field is 0 and its timer field is nonzero, only timer expiry raises that direction's interrupt, however many completions arrive.
- R5: The receive timer (bits 23:20, value T) starts at the first completion after an interrupt or write. The interrupt appears one cycle after the T-th unit tick that follows that completion's cycle. If the count threshold is reached first, the count wins and the timer clears.
- R6: The transmit timer (bits 30:27, value T) counts in steps of 16 unit ticks, so it expires on the 16*T-th unit tick after the starting completion.
- R7: With bit 31 at 0, the unit tick is every base tick. With bit 31 at 1, the unit tick is every eighth base tick, counted from the last control write.
- R8: With bit 16 set, mitigation re-arms after each moderated interrupt. With bit 16 clear, after one moderated interrupt that direction passes completions through until the control word is written again, and that write re-arms it.
- R9: The readback returns the last written control word. A write discards all pending counts and running timers.
- R10: Activity on one direction never raises the other direction's interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Base time tick, one-cycle pulse |
| rxDone | input | 1 | Receive completion pulse |
| txDone | input | 1 | Transmit completion pulse |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word write data |
| cfgRdData | output | 32 | Control word readback |
| rxIrq | output | 1 | Moderated receive interrupt pulse |
| txIrq | output | 1 | Moderated transmit interrupt pulse |

## Verification
The assertions check several properties on every cycle. An unmoderated completion always produces an interrupt in the following cycle. The packet counter and the elapsed-time counter never reach their thresholds without firing. No interrupt can appear while count-triggering is off and no timer is running. A one-shot moderated interrupt always drops the direction back to pass-through, and the divided unit tick never occurs on two cycles in a row. Only the bench scenarios can show the absolute timing. These cover the exact number of unit ticks before expiry for each direction and tick size, the counting of completions between interrupts, re-arming after continuous-mode interrupts, re-arming on a rewrite after one-shot use, and the independence of the two directions.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int CFG_W      = 32;
  localparam int CNT_W      = 3;
  localparam int TMR_W      = 4;
  localparam int CYC_BIT    = 31;
  localparam int TX_TMR_LSB = 27;
  localparam int TX_CNT_LSB = 24;
  localparam int RX_TMR_LSB = 20;
  localparam int RX_CNT_LSB = 17;
  localparam int CM_BIT     = 16;
  localparam int NUM_LANES  = 2;
  localparam int LANE_RX    = 0;
  localparam int LANE_TX    = 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 unitTick;
    logic                 clear;
    logic [NUM_LANES-1:0] mitEn;
  } imcStrobe_t;
endpackage

// File: rtl/imc_lane.sv
module imc_lane
  import imc_pkg::*;
#(
  parameter int LCNT_W = CNT_W,
  parameter int LTMR_W = TMR_W,
  parameter int SUB_W  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              done,
  input  logic              unitTick,
  input  logic              clear,
  input  logic              mitEn,
  input  logic [LCNT_W-1:0] cntThr,
  input  logic [LTMR_W-1:0] tmrThr,
  output logic              irq,
  output logic              fireMit
);
  logic [LCNT_W-1:0] pktCnt;
  logic [LTMR_W-1:0] elapsed;
  logic              active;
  logic              subWrap;
  logic              cntHit;
  logic              tmrHit;
  logic              passThru;
  logic              flush;
  logic [LCNT_W:0]   cntNext;
  logic [LTMR_W:0]   tmrNext;

  assign cntNext  = {1'b0, pktCnt} + 1'b1;
  assign tmrNext  = {1'b0, elapsed} + 1'b1;
  assign cntHit   = done && (cntThr != '0) && (cntNext == {1'b0, cntThr});
  assign tmrHit   = active && (tmrThr != '0) && unitTick && subWrap &&
                    (tmrNext == {1'b0, tmrThr});
  assign fireMit  = mitEn && (cntHit || tmrHit);
  assign passThru = !mitEn && done;
  assign flush    = clear || fireMit || !mitEn;

  // Optional coarse prescale of the timer
  generate
    if (SUB_W > 0) begin : g_sub
      logic [SUB_W-1:0] subCnt;
      always_ff @(posedge clk) begin
        if (!rstN) subCnt <= '0;
        else if (flush || !active) subCnt <= '0;
        else if (unitTick) subCnt <= subCnt + 1'b1;
      end
      assign subWrap = &subCnt;
    end else begin : g_nosub
      assign subWrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq     <= 1'b0;
      pktCnt  <= '0;
      elapsed <= '0;
      active  <= 1'b0;
    end else begin
      irq <= fireMit || passThru;
      if (flush) begin
        pktCnt  <= '0;
        elapsed <= '0;
        active  <= 1'b0;
      end else begin
        if (done && (cntThr != '0)) pktCnt <= pktCnt + 1'b1;
        if (done && (tmrThr != '0)) active <= 1'b1;
        if (active && unitTick && subWrap) elapsed <= elapsed + 1'b1;
      end
    end
  end

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (!mitEn && done) |=> irq);
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (mitEn && (cntThr != '0)) |-> (pktCnt < cntThr));
  a_r5_tmr_bound: assert property (@(posedge clk) disable iff (!rstN)
    (mitEn && active) |-> (elapsed < tmrThr));
  a_r4_no_early: assert property (@(posedge clk) disable iff (!rstN)
    (mitEn && (cntThr == '0) && !active) |=> !irq);
endmodule

// File: rtl/imc_dp.sv
module imc_dp
  import imc_pkg::*;
#(
  parameter int TX_SUB_W = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  imcStrobe_t                      strobe,
  input  logic [NUM_LANES-1:0]            done,
  input  logic [NUM_LANES-1:0][CNT_W-1:0] cntThr,
  input  logic [NUM_LANES-1:0][TMR_W-1:0] tmrThr,
  output logic [NUM_LANES-1:0]            irq,
  output logic [NUM_LANES-1:0]            fireMit
);
  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int SW = (i == LANE_TX) ? TX_SUB_W : 0;
      imc_lane #(
        .LCNT_W(CNT_W),
        .LTMR_W(TMR_W),
        .SUB_W (SW)
      ) i_lane (
        .clk     (clk),
        .rstN    (rstN),
        .done    (done[i]),
        .unitTick(strobe.unitTick),
        .clear   (strobe.clear),
        .mitEn   (strobe.mitEn[i]),
        .cntThr  (cntThr[i]),
        .tmrThr  (tmrThr[i]),
        .irq     (irq[i]),
        .fireMit (fireMit[i])
      );
    end
  endgenerate
endmodule

// File: rtl/imc_ctrl.sv
module imc_ctrl
  import imc_pkg::*;
#(
  parameter int DIV_LOG2 = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            baseTick,
  input  logic                            cfgWrEn,
  input  logic [CFG_W-1:0]                cfgWrData,
  input  logic [NUM_LANES-1:0]            fireMit,
  output imcStrobe_t                      strobe,
  output logic [CFG_W-1:0]                cfgWord,
  output logic [NUM_LANES-1:0][CNT_W-1:0] cntThr,
  output logic [NUM_LANES-1:0][TMR_W-1:0] tmrThr
);
  logic [DIV_LOG2-1:0]  pre;
  logic [NUM_LANES-1:0] armed;

  assign cntThr[LANE_RX] = cfgWord[RX_CNT_LSB +: CNT_W];
  assign cntThr[LANE_TX] = cfgWord[TX_CNT_LSB +: CNT_W];
  assign tmrThr[LANE_RX] = cfgWord[RX_TMR_LSB +: TMR_W];
  assign tmrThr[LANE_TX] = cfgWord[TX_TMR_LSB +: TMR_W];

  assign strobe.unitTick = cfgWord[CYC_BIT] ? (baseTick && (&pre)) : baseTick;
  assign strobe.clear    = cfgWrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWord <= '0;
      pre     <= '0;
    end else if (cfgWrEn) begin
      cfgWord <= cfgWrData;
      pre     <= '0;
    end else if (baseTick) begin
      pre <= pre + 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_arm
      assign strobe.mitEn[i] = armed[i] && ((cntThr[i] != '0) || (tmrThr[i] != '0));

      always_ff @(posedge clk) begin
        if (!rstN) armed[i] <= 1'b0;
        else if (cfgWrEn) armed[i] <= 1'b1;
        else if (fireMit[i] && !cfgWord[CM_BIT]) armed[i] <= 1'b0;
      end

      a_r8_oneshot_disarm: assert property (@(posedge clk) disable iff (!rstN)
        (fireMit[i] && !cfgWord[CM_BIT] && !cfgWrEn) |=> !strobe.mitEn[i]);
    end
  endgenerate

  a_r9_readback: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgWord == $past(cfgWrData)));
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord[CYC_BIT] && strobe.unitTick && !cfgWrEn) |=> !strobe.unitTick);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import imc_pkg::*;
#(
  parameter int DIV_LOG2 = 3,
  parameter int TX_SUB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseTick,
  input  logic             rxDone,
  input  logic             txDone,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             rxIrq,
  output logic             txIrq
);
  imcStrobe_t                      strobe;
  logic [NUM_LANES-1:0][CNT_W-1:0] cntThr;
  logic [NUM_LANES-1:0][TMR_W-1:0] tmrThr;
  logic [NUM_LANES-1:0]            fireMit;
  logic [NUM_LANES-1:0]            irq;
  logic [NUM_LANES-1:0]            done;

  assign done[LANE_RX] = rxDone;
  assign done[LANE_TX] = txDone;
  assign rxIrq = irq[LANE_RX];
  assign txIrq = irq[LANE_TX];

  imc_ctrl #(.DIV_LOG2(DIV_LOG2)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baseTick (baseTick),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .fireMit  (fireMit),
    .strobe   (strobe),
    .cfgWord  (cfgRdData),
    .cntThr   (cntThr),
    .tmrThr   (tmrThr)
  );

  imc_dp #(.TX_SUB_W(TX_SUB_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .done   (done),
    .cntThr (cntThr),
    .tmrThr (tmrThr),
    .irq    (irq),
    .fireMit(fireMit)
  );
endmodule

// File: tb/test_irq_moderator.sv
module test_irq_moderator;
  localparam int CLK_PERIOD = 10;
  localparam int CAP        = 2100;
  localparam int NVEC       = 12;

  // {cfg[63:32], isTx[31:28], nPkts[27:24], expIrqs[23:16], expWait[15:0]}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0000, 4'd0, 4'd3, 8'd3, 16'd0},
    {32'h0000_0000, 4'd1, 4'd2, 8'd2, 16'd0},
    {32'h0005_0000, 4'd0, 4'd5, 8'd2, 16'd0},
    {32'h0051_0000, 4'd0, 4'd3, 8'd0, 16'd5},
    {32'h0047_0000, 4'd0, 4'd2, 8'd0, 16'd4},
    {32'h1001_0000, 4'd1, 4'd1, 8'd0, 16'd32},
    {32'h0401_0000, 4'd1, 4'd4, 8'd1, 16'd0},
    {32'h8031_0000, 4'd0, 4'd1, 8'd0, 16'd24},
    {32'h80F1_0000, 4'd0, 4'd1, 8'd0, 16'd120},
    {32'h0004_0000, 4'd0, 4'd5, 8'd4, 16'd0},
    {32'h0200_0000, 4'd1, 4'd3, 8'd2, 16'd0},
    {32'h0005_0000, 4'd1, 4'd2, 8'd2, 16'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseTick = 1'b0;
  logic        rxDone = 1'b0;
  logic        txDone = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        rxIrq;
  logic        txIrq;

  int checks = 0;
  int errors = 0;
  int selCnt = 0;
  int othCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_moderator i_irq_moderator (
    .clk      (clk),
    .rstN     (rstN),
    .baseTick (baseTick),
    .rxDone   (rxDone),
    .txDone   (txDone),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .rxIrq    (rxIrq),
    .txIrq    (txIrq)
  );

  function automatic string reqOf(int idx);
    case (idx)
      0, 1:    return "R2";
      2:       return "R3";
      3:       return "R4";
      4:       return "R5";
      5:       return "R6";
      6:       return "R3";
      7, 8:    return "R7";
      9, 10:   return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sampleIrq(input bit isTx);
    if (isTx ? txIrq : rxIrq) selCnt++;
    if (isTx ? rxIrq : txIrq) othCnt++;
  endtask

  task automatic writeCfg(input logic [31:0] w);
    cfgWrEn = 1'b1;
    cfgWrData = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendPkt(input bit isTx);
    if (isTx) txDone = 1'b1; else rxDone = 1'b1;
    @(negedge clk);
    rxDone = 1'b0;
    txDone = 1'b0;
    sampleIrq(isTx);
    @(negedge clk);
    sampleIrq(isTx);
  endtask

  task automatic tickUntil(input bit isTx, output int waited);
    waited = 0;
    baseTick = 1'b1;
    for (int t = 1; t <= CAP; t++) begin
      @(negedge clk);
      if (isTx ? rxIrq : txIrq) othCnt++;
      if (isTx ? txIrq : rxIrq) begin
        waited = t;
        break;
      end
    end
    baseTick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int waited;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rxIrq == 1'b0, "R1", "rxIrq in reset", int'(rxIrq), 0);
    check(txIrq == 1'b0, "R1", "txIrq in reset", int'(txIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cfgRdData == 32'h0, "R1", "readback after reset", int'(cfgRdData), 0);
    selCnt = 0; othCnt = 0;
    sendPkt(1'b0);
    check(selCnt == 1, "R1", "pass-through after reset", selCnt, 1);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] cfg;
      bit          isTx;
      int          nPkts, expIrqs, expWait;
      cfg     = VEC[v][63:32];
      isTx    = VEC[v][28];
      nPkts   = int'(VEC[v][27:24]);
      expIrqs = int'(VEC[v][23:16]);
      expWait = int'(VEC[v][15:0]);
      writeCfg(cfg);
      selCnt = 0; othCnt = 0;
      for (int p = 0; p < nPkts; p++) sendPkt(isTx);
      check(selCnt == expIrqs, reqOf(v), $sformatf("vec %0d irqs during packets", v),
            selCnt, expIrqs);
      tickUntil(isTx, waited);
      check(waited == expWait, reqOf(v), $sformatf("vec %0d ticks to timer irq", v),
            waited, expWait);
      check(othCnt == 0, "R10", $sformatf("vec %0d other direction irqs", v), othCnt, 0);
    end

    // R9: readback
    writeCfg(32'h80F1_0000);
    @(negedge clk);
    check(cfgRdData == 32'h80F1_0000, "R9", "readback", int'(cfgRdData), 32'h80F1_0000);

    // R8: continuous mode re-arms the timer after each interrupt
    writeCfg(32'h0021_0000);
    selCnt = 0;
    sendPkt(1'b0);
    tickUntil(1'b0, waited);
    check(waited == 2, "R8", "continuous first timer irq", waited, 2);
    selCnt = 0;
    sendPkt(1'b0);
    check(selCnt == 0, "R8", "continuous second packet held", selCnt, 0);
    tickUntil(1'b0, waited);
    check(waited == 2, "R8", "continuous second timer irq", waited, 2);

    // R8: one-shot drops to pass-through, rewrite re-arms
    writeCfg(32'h0020_0000);
    selCnt = 0;
    sendPkt(1'b0);
    tickUntil(1'b0, waited);
    check(waited == 2, "R8", "one-shot timer irq", waited, 2);
    selCnt = 0;
    sendPkt(1'b0);
    check(selCnt == 1, "R8", "one-shot then pass-through", selCnt, 1);
    writeCfg(32'h0020_0000);
    selCnt = 0;
    sendPkt(1'b0);
    check(selCnt == 0, "R8", "rewrite re-arms", selCnt, 0);

    // R9: write discards a running timer
    writeCfg(32'h0020_0000);
    selCnt = 0; othCnt = 0;
    tickUntil(1'b0, waited);
    check(waited == 0, "R9", "write clears pending timer", waited, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule